// File: doc/BRIEF.md
# USB Device Link State Tracker

This block follows the link state of a USB device from the bus's point of view. Its inputs are two levels and several pulses. The levels are the supply sense and the pull-up enable. The pulses are bus reset, bus idle, bus wake, start-of-frame seen, J state seen and a resume request. Other logic filters the line and times the intervals, and delivers the results here as single-cycle events. This block only decides which state the link is in.

There are seven states:

- detached
- powered
- powered and idle
- resuming
- active waiting for a first frame marker
- active
- suspended

The state is available as a 3-bit code. Four decoded flags are also provided: disconnected, powered, suspended and active. A loss of supply or pull-up overrides everything else and returns the tracker to detached. An active-low asynchronous reset does the same.

Top module: `usb_link_tracker`

## Requirements
- R1: During and after reset, the state code is 0 (detached) and only the disconnected flag is high. The state codes are: 0 detached, 1 powered, 2 powered-idle, 3 resuming, 4 active-no-frame, 5 active, 6 suspended.
- R2: In any state, if supply sense or pull-up enable is low at a clock edge, the next state is detached, whatever events are present.
- R3: Detached moves to powered only when supply sense and pull-up enable are both high. Bus reset, wake and SOF events have no effect while detached.
- R4: In powered, bus reset takes priority and goes to active-no-frame. Next, a resume request goes to resuming. Next, bus idle goes to powered-idle. SOF alone has no effect.
- R5: In powered-idle, bus reset goes to active-no-frame. Otherwise bus wake returns to powered.
- R6: In resuming, a J state or a bus reset goes to active-no-frame. With neither present, the state is held.
- R7: In active-no-frame, bus idle takes priority and goes to suspended. Otherwise an SOF goes to active.
- R8: In active, bus idle takes priority and goes to suspended. Otherwise bus reset goes to active-no-frame.
- R9: In suspended, bus reset goes to active-no-frame. Otherwise bus wake goes to resuming.
- R10: The suspended flag is high in powered-idle and suspended. The active flag is high in active and active-no-frame. The disconnected flag is high only in detached.
- R11: The powered flag is supply sense ANDed with (state is powered or the active flag is high). It follows supply sense in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbus_sense_i | input | 1 | Supply sense level |
| pullup_en_i | input | 1 | Pull-up enable level |
| bus_reset_i | input | 1 | Bus reset event pulse |
| bus_idle_i | input | 1 | Bus inactivity event pulse |
| bus_wake_i | input | 1 | Bus activity event pulse |
| sof_seen_i | input | 1 | Start-of-frame detected pulse |
| jstate_seen_i | input | 1 | J state detected pulse |
| resume_req_i | input | 1 | Resume request pulse |
| link_state_o | output | 3 | Encoded link state |
| st_disconnected_o | output | 1 | Detached flag |
| st_powered_o | output | 1 | Powered flag |
| st_suspended_o | output | 1 | Suspended flag |
| st_active_o | output | 1 | Active flag |

## Verification
Each state is entered and then given events one at a time. This shows that each transition is taken only on its own trigger. Events are then applied together in pairs and triples, which tells the priority orders apart: reset over resume over idle in powered, and idle over SOF or reset in the active states. Events that do not apply to the current state are applied, so that they are seen to leave the state unchanged. Supply or pull-up is dropped while other events are present, to show that the override wins. Supply is toggled in the active states to show that the powered flag follows it combinationally.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;
  localparam int LS_W = 3;

  typedef enum logic [LS_W-1:0] {
    LS_DETACHED  = 3'd0,
    LS_POWERED   = 3'd1,
    LS_PWR_IDLE  = 3'd2,
    LS_RESUMING  = 3'd3,
    LS_ACT_NOSOF = 3'd4,
    LS_ACTIVE    = 3'd5,
    LS_SUSPENDED = 3'd6
  } link_state_e;

  typedef struct packed {
    logic bus_reset;
    logic bus_idle;
    logic bus_wake;
    logic sof_seen;
    logic jstate_seen;
    logic resume_req;
  } link_evt_t;

  function automatic logic is_active(input link_state_e s);
    return (s == LS_ACTIVE) || (s == LS_ACT_NOSOF);
  endfunction

  function automatic logic is_suspended(input link_state_e s);
    return (s == LS_SUSPENDED) || (s == LS_PWR_IDLE);
  endfunction
endpackage

// File: rtl/usb_link_next.sv
module usb_link_next
  import usb_link_pkg::*;
(
  input  link_state_e cur_i,
  input  logic        live_i,
  input  link_evt_t   evt_i,
  output link_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!live_i) begin
      nxt_o = LS_DETACHED;
    end else begin
      unique case (cur_i)
        LS_DETACHED:  nxt_o = LS_POWERED;
        LS_POWERED: begin
          if (evt_i.bus_reset)       nxt_o = LS_ACT_NOSOF;
          else if (evt_i.resume_req) nxt_o = LS_RESUMING;
          else if (evt_i.bus_idle)   nxt_o = LS_PWR_IDLE;
        end
        LS_PWR_IDLE: begin
          if (evt_i.bus_reset)       nxt_o = LS_ACT_NOSOF;
          else if (evt_i.bus_wake)   nxt_o = LS_POWERED;
        end
        LS_RESUMING: begin
          if (evt_i.jstate_seen || evt_i.bus_reset) nxt_o = LS_ACT_NOSOF;
        end
        LS_ACT_NOSOF: begin
          if (evt_i.bus_idle)        nxt_o = LS_SUSPENDED;
          else if (evt_i.sof_seen)   nxt_o = LS_ACTIVE;
        end
        LS_ACTIVE: begin
          if (evt_i.bus_idle)        nxt_o = LS_SUSPENDED;
          else if (evt_i.bus_reset)  nxt_o = LS_ACT_NOSOF;
        end
        LS_SUSPENDED: begin
          if (evt_i.bus_reset)       nxt_o = LS_ACT_NOSOF;
          else if (evt_i.bus_wake)   nxt_o = LS_RESUMING;
        end
        default:      nxt_o = LS_DETACHED;
      endcase
    end
  end
endmodule

// File: rtl/usb_link_status.sv
module usb_link_status
  import usb_link_pkg::*;
(
  input  link_state_e st_i,
  input  logic        vbus_i,
  output logic        disc_o,
  output logic        pwr_o,
  output logic        susp_o,
  output logic        act_o
);
  logic act_w;
  assign act_w  = is_active(st_i);
  assign act_o  = act_w;
  assign susp_o = is_suspended(st_i);
  assign disc_o = (st_i == LS_DETACHED);
  assign pwr_o  = vbus_i & ((st_i == LS_POWERED) | act_w);
endmodule

// File: rtl/usb_link_tracker.sv
module usb_link_tracker
  import usb_link_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vbus_sense_i,
  input  logic            pullup_en_i,
  input  logic            bus_reset_i,
  input  logic            bus_idle_i,
  input  logic            bus_wake_i,
  input  logic            sof_seen_i,
  input  logic            jstate_seen_i,
  input  logic            resume_req_i,
  output logic [LS_W-1:0] link_state_o,
  output logic            st_disconnected_o,
  output logic            st_powered_o,
  output logic            st_suspended_o,
  output logic            st_active_o
);
  link_state_e state_q, state_d;
  link_evt_t   evt_w;
  logic        live_w;

  assign live_w = vbus_sense_i & pullup_en_i;
  assign evt_w  = '{bus_reset:   bus_reset_i,
                    bus_idle:    bus_idle_i,
                    bus_wake:    bus_wake_i,
                    sof_seen:    sof_seen_i,
                    jstate_seen: jstate_seen_i,
                    resume_req:  resume_req_i};

  usb_link_next u_next (
    .cur_i  (state_q),
    .live_i (live_w),
    .evt_i  (evt_w),
    .nxt_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_DETACHED;
    else         state_q <= state_d;
  end

  usb_link_status u_status (
    .st_i   (state_q),
    .vbus_i (vbus_sense_i),
    .disc_o (st_disconnected_o),
    .pwr_o  (st_powered_o),
    .susp_o (st_suspended_o),
    .act_o  (st_active_o)
  );

  assign link_state_o = state_q;
endmodule

// File: rtl/usb_link_tracker_chk.sv
module usb_link_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vbus_sense_i,
  input logic       pullup_en_i,
  input logic       bus_reset_i,
  input logic       bus_idle_i,
  input logic       sof_seen_i,
  input logic [2:0] link_state_o,
  input logic       st_disconnected_o,
  input logic       st_powered_o,
  input logic       st_suspended_o,
  input logic       st_active_o
);
  logic live;
  assign live = vbus_sense_i & pullup_en_i;

  assert_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> link_state_o == 3'd0);

  assert_hold_detached_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd0 && !live) |=> link_state_o == 3'd0);

  assert_reset_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd1 && live && bus_reset_i) |=> link_state_o == 3'd4);

  assert_sof_promote_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd4 && live && !bus_idle_i && sof_seen_i) |=> link_state_o == 3'd5);

  assert_idle_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd5 && live && bus_idle_i) |=> link_state_o == 3'd6);

  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({st_disconnected_o, st_suspended_o, st_active_o}) <= 1);

  assert_pwr_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_sense_i |-> !st_powered_o);
endmodule

bind usb_link_tracker usb_link_tracker_chk u_chk (.*);

// File: tb/usb_link_tracker_bench.sv
`timescale 1ns/1ps
module usb_link_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vb = 0, pu = 0, brst = 0, idle = 0, wake = 0, sof = 0, jst = 0, rsm = 0;
  logic [2:0] st;
  logic f_disc, f_pwr, f_susp, f_act;
  int n_chk = 0, n_fail = 0;
  int mstate = 0;

  always #4 clk = ~clk;

  usb_link_tracker u_usb_link_tracker (
    .clk_i(clk), .rst_ni(rst_n), .vbus_sense_i(vb), .pullup_en_i(pu),
    .bus_reset_i(brst), .bus_idle_i(idle), .bus_wake_i(wake), .sof_seen_i(sof),
    .jstate_seen_i(jst), .resume_req_i(rsm), .link_state_o(st),
    .st_disconnected_o(f_disc), .st_powered_o(f_pwr),
    .st_suspended_o(f_susp), .st_active_o(f_act));

  // Behavioural reference: state numbers per R1.
  function automatic int ref_next(int s);
    if (!(vb && pu)) return 0;                                        // R2
    case (s)
      0: return 1;                                                    // R3
      1: return brst ? 4 : rsm ? 3 : idle ? 2 : 1;                    // R4
      2: return brst ? 4 : wake ? 1 : 2;                              // R5
      3: return (jst || brst) ? 4 : 3;                                // R6
      4: return idle ? 6 : sof ? 5 : 4;                               // R7
      5: return idle ? 6 : brst ? 4 : 5;                              // R8
      6: return brst ? 4 : wake ? 3 : 6;                              // R9
      default: return 0;
    endcase
  endfunction

  function automatic logic [6:0] ref_out(int s);
    logic a;
    a = (s == 4) || (s == 5);
    return {3'(s), s == 0, vb && (s == 1 || a), (s == 2 || s == 6), a}; // R10 R11
  endfunction

  task automatic compare(string tag);
    logic [6:0] got, exp;
    got = {st, f_disc, f_pwr, f_susp, f_act};
    exp = ref_out(mstate);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got state=%0d d/p/s/a=%b expected state=%0d d/p/s/a=%b",
               tag, got[6:4], got[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  // Drive inputs at negedge, compare, then let the model advance at posedge.
  task automatic step(string tag, logic v, logic p, logic r, logic i, logic w,
                      logic s, logic j, logic q);
    int nx;
    @(negedge clk);
    vb = v; pu = p; brst = r; idle = i; wake = w; sof = s; jst = j; rsm = q;
    #1 compare(tag);
    nx = ref_next(mstate);
    @(posedge clk);
    mstate = nx;
  endtask

  task automatic quiet(string tag);
    step(tag, 1, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 compare("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    #1 compare("R1 after reset");
    // R3: one level alone keeps detached; events ignored
    step("R3 vbus only",   1, 0, 1, 0, 1, 1, 0, 0);
    step("R3 pullup only", 0, 1, 1, 0, 1, 1, 0, 0);
    step("R3 both",        1, 1, 1, 0, 1, 1, 0, 0);
    // R4 priorities
    step("R4 sof ignored", 1, 1, 0, 0, 0, 1, 0, 0);
    step("R4 idle",        1, 1, 0, 1, 0, 0, 0, 0);
    step("R5 wake",        1, 1, 0, 0, 1, 0, 0, 0);
    step("R4 resume+idle", 1, 1, 0, 1, 0, 0, 0, 1);
    step("R6 hold",        1, 1, 0, 0, 1, 1, 0, 0);
    step("R6 jstate",      1, 1, 0, 0, 0, 0, 1, 0);
    step("R8 pre", 1, 1, 0, 0, 0, 0, 0, 0);
    step("R2 drop pullup", 1, 0, 1, 0, 0, 1, 0, 0);
    quiet("R3 reconnect");
    step("R4 all three",   1, 1, 1, 1, 0, 0, 0, 1);
    step("R7 sof",         1, 1, 0, 0, 0, 1, 0, 0);
    step("R11 vbus low",   0, 1, 0, 0, 0, 0, 0, 0);
    quiet("R2 after vbus drop");
    step("R4 idle", 1, 1, 0, 1, 0, 0, 0, 0);
    step("R5 reset+wake",  1, 1, 1, 0, 1, 0, 0, 0);
    step("R7 idle+sof",    1, 1, 0, 1, 0, 1, 0, 0);
    step("R9 reset+wake",  1, 1, 1, 0, 1, 0, 0, 0);
    step("R7 sof",         1, 1, 0, 0, 0, 1, 0, 0);
    step("R8 reset",       1, 1, 1, 0, 0, 0, 0, 0);
    step("R7 sof",         1, 1, 0, 0, 0, 1, 0, 0);
    step("R8 idle+reset",  1, 1, 1, 1, 0, 0, 0, 0);
    step("R10 suspended",  1, 1, 0, 0, 0, 1, 1, 0);
    step("R9 wake",        1, 1, 0, 0, 1, 0, 0, 0);
    step("R6 reset",       1, 1, 1, 0, 0, 0, 0, 0);
    step("R11 active vbus low", 0, 1, 0, 0, 0, 0, 0, 0);
    quiet("R2 detached");
    quiet("R10 powered");
    step("R4 resume",      1, 1, 0, 0, 0, 0, 0, 1);
    step("R2 drop with events", 0, 0, 1, 1, 1, 1, 1, 1);
    quiet("R1 detached again");
    @(negedge clk); #1 compare("R10 final");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule